// File: doc/BRIEF.md
# Integer Add/Subtract and Decimal-Adjust Unit

This unit is the add/subtract slice of a small processor datapath. Each accepted request carries an operation code, an operand size, a destination value, a source value, a flag that marks the source as an immediate, a small step constant and the current condition flags. One clock later the unit presents the new destination value, the new flags and an error bit. A done strobe marks that cycle.

Plain add and subtract work on every size. The carry-chained forms and the decimal adjustments work only on bytes. Increment and decrement take small steps. An address-style add or subtract works only on 32-bit values and leaves the flags alone. Each operation accepts only some sizes and steps. A request that breaks these rules sets the error bit and changes nothing.

Top module: `arith_unit`

## Requirements
- R1: After reset, result_o, flags_o, err_o and done_o are all zero. done_o is high exactly one cycle after each cycle with valid_i high. result_o, flags_o and err_o change only in that cycle.
- R2: Operation codes are 0 add, 1 subtract, 2 add with carry, 3 subtract with borrow, 4 increment, 5 decrement, 6 address add, 7 address subtract, 8 decimal adjust after add, 9 decimal adjust after subtract. Sizes are 0 byte, 1 word (16-bit) and 2 long (32-bit). Size 3 and codes 10 to 15 are illegal. The flags vector is {H,N,Z,V,C}, with C in bit 0 and H in bit 4.
- R3: Add and subtract of src_i work on all three sizes. C is the carry or borrow out. V is signed overflow. N is the result's top bit and Z is set on a zero result. H is the carry or borrow out of bit 3, 11 or 27 for byte, word or long.
- R4: A byte subtract with imm_sel_i=1 is illegal.
- R5: Add with carry and subtract with borrow are byte-only and fold flag C into the result. Z is cleared on a nonzero result and otherwise keeps its input value.
- R6: Increment and decrement use step_i as the operand. Step 1 or 2 is legal for word and long, and only step 1 for byte. They update N, Z and V and keep H and C.
- R7: Address add and subtract are legal only at size long, with step 1, 2 or 4. They leave all five flags unchanged.
- R8: Decimal adjust after add is byte-only. It adds 0x06 when H=1 or the low nibble exceeds 9. It adds 0x60 when C=1 or the byte exceeds 0x99, and C is set to whether 0x60 was added.
- R9: Decimal adjust after subtract is byte-only. It subtracts 0x06 when H=1 and 0x60 when C=1. Both decimal adjusts set N and Z from the result and keep V, H and, for the subtract form, C.
- R10: For byte and word sizes, result_o bits above the operand width equal those of dst_i.
- R11: An illegal request sets err_o. result_o then equals dst_i and flags_o equals flags_i. A legal request clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size |
| imm_sel_i | input | 1 | Source is an immediate |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| step_i | input | 3 | Step constant |
| flags_i | input | 5 | Current flags {H,N,Z,V,C} |
| result_o | output | 32 | New destination value |
| flags_o | output | 5 | New flags |
| err_o | output | 1 | Illegal request |
| done_o | output | 1 | Outputs updated this cycle |

## Verification
The assertions watch, on every cycle, the rules that hold for any operands. The done strobe follows the request, and the outputs hold between requests. An illegal size always sets the error bit, and an error leaves the value and the flags untouched. Narrow sizes keep the upper destination bits, and address arithmetic never touches a flag. The actual sums, the flag values, the legality of each size and step pair, and the decimal corrections depend on operand values. Only the bench's directed scenarios show those, with hand-worked expected results.

// File: rtl/arith_pkg.sv
package arith_pkg;
  localparam int DW = 32;
  localparam int FW = 5;
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;
  localparam int FL_H = 4;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_ADDC   = 4'd2,
    OP_SUBC   = 4'd3,
    OP_INC    = 4'd4,
    OP_DEC    = 4'd5,
    OP_ADRADD = 4'd6,
    OP_ADRSUB = 4'd7,
    OP_DECADD = 4'd8,
    OP_DECSUB = 4'd9
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;
endpackage

// File: rtl/arith_addsub.sv
module arith_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c,
  output logic         v,
  output logic         h
);
  localparam int HW = W - 4;

  logic [W-1:0]  bx;
  logic          cadd;
  logic [W:0]    full;
  logic [HW:0]   half;

  assign bx   = sub ? ~b : b;
  assign cadd = sub ? ~cin : cin;
  assign full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cadd};
  assign half = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cadd};
  assign res  = full[W-1:0];
  assign c    = full[W] ^ sub;
  assign h    = half[HW] ^ sub;
  assign v    = (a[W-1] == bx[W-1]) && (res[W-1] != a[W-1]);
endmodule

// File: rtl/arith_decadj.sv
module arith_decadj (
  input  logic [7:0] a,
  input  logic       sub,
  input  logic       c_in,
  input  logic       h_in,
  output logic [7:0] res,
  output logic       c_out
);
  logic       lo_fix;
  logic       hi_fix;
  logic [7:0] corr;

  always_comb begin
    if (sub) begin
      lo_fix = h_in;
      hi_fix = c_in;
    end else begin
      lo_fix = h_in || (a[3:0] > 4'd9);
      hi_fix = c_in || (a > 8'h99);
    end
    corr  = (lo_fix ? 8'h06 : 8'h00) | (hi_fix ? 8'h60 : 8'h00);
    res   = sub ? (a - corr) : (a + corr);
    c_out = sub ? c_in : hi_fix;
  end
endmodule

// File: rtl/arith_legal.sv
module arith_legal
  import arith_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] size,
  input  logic       imm_sel,
  input  logic [2:0] step,
  output logic       illegal
);
  logic is_byte;
  logic is_long;
  assign is_byte = (size == SZ_BYTE);
  assign is_long = (size == SZ_LONG);

  always_comb begin
    illegal = 1'b0;
    if (size == 2'd3) begin
      illegal = 1'b1;
    end else begin
      case (op)
        OP_ADD:                 illegal = 1'b0;
        OP_SUB:                 illegal = is_byte && imm_sel;
        OP_ADDC, OP_SUBC,
        OP_DECADD, OP_DECSUB:   illegal = !is_byte;
        OP_INC, OP_DEC:         illegal = is_byte ? (step != 3'd1)
                                                  : !(step == 3'd1 || step == 3'd2);
        OP_ADRADD, OP_ADRSUB:   illegal = !is_long ||
                                          !(step == 3'd1 || step == 3'd2 || step == 3'd4);
        default:                illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit
  import arith_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic          imm_sel_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [2:0]    step_i,
  input  logic [FW-1:0] flags_i,
  output logic [DW-1:0] result_o,
  output logic [FW-1:0] flags_o,
  output logic          err_o,
  output logic          done_o
);
  localparam int NLANE = 3;

  logic [DW-1:0] opnd;
  logic          sub;
  logic          cin;
  logic          illegal;
  logic [1:0]    lane_sel;
  logic [DW-1:0] lane_res [NLANE];
  logic          lane_c   [NLANE];
  logic          lane_v   [NLANE];
  logic          lane_h   [NLANE];
  logic          lane_n   [NLANE];
  logic [7:0]    da_res;
  logic          da_c;
  logic [DW-1:0] nxt_res;
  logic [FW-1:0] nxt_flags;
  logic [DW-1:0] sel_res;
  logic          sel_z;

  logic [DW-1:0] result_q;
  logic [FW-1:0] flags_q;
  logic          err_q;
  logic          done_q;

  arith_legal u_legal (
    .op(op_i), .size(size_i), .imm_sel(imm_sel_i), .step(step_i), .illegal(illegal)
  );

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC: opnd = src_i;
      default:                          opnd = {{(DW-3){1'b0}}, step_i};
    endcase
    sub = (op_i == OP_SUB) || (op_i == OP_SUBC) ||
          (op_i == OP_DEC) || (op_i == OP_ADRSUB);
    cin = ((op_i == OP_ADDC) || (op_i == OP_SUBC)) ? flags_i[FL_C] : 1'b0;
    lane_sel = ((op_i == OP_ADRADD) || (op_i == OP_ADRSUB)) ? SZ_LONG : size_i;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] r;
    arith_addsub #(.W(LW)) u_add (
      .a(dst_i[LW-1:0]), .b(opnd[LW-1:0]), .sub(sub), .cin(cin),
      .res(r), .c(lane_c[g]), .v(lane_v[g]), .h(lane_h[g])
    );
    if (LW < DW) begin : g_merge
      assign lane_res[g] = {dst_i[DW-1:LW], r};
    end else begin : g_full
      assign lane_res[g] = r;
    end
    assign lane_n[g] = r[LW-1];
  end

  arith_decadj u_dec (
    .a(dst_i[7:0]), .sub(op_i == OP_DECSUB), .c_in(flags_i[FL_C]),
    .h_in(flags_i[FL_H]), .res(da_res), .c_out(da_c)
  );

  always_comb begin
    sel_res = lane_res[0];
    sel_z   = (lane_res[0][7:0] == 8'h00);
    if (lane_sel == SZ_WORD) begin
      sel_res = lane_res[1];
      sel_z   = (lane_res[1][15:0] == 16'h0000);
    end else if (lane_sel == SZ_LONG) begin
      sel_res = lane_res[2];
      sel_z   = (lane_res[2] == '0);
    end
  end

  always_comb begin
    nxt_res   = sel_res;
    nxt_flags = flags_i;
    case (op_i)
      OP_ADD, OP_SUB: begin
        nxt_flags[FL_H] = lane_h[lane_sel];
        nxt_flags[FL_N] = lane_n[lane_sel];
        nxt_flags[FL_Z] = sel_z;
        nxt_flags[FL_V] = lane_v[lane_sel];
        nxt_flags[FL_C] = lane_c[lane_sel];
      end
      OP_ADDC, OP_SUBC: begin
        nxt_flags[FL_H] = lane_h[0];
        nxt_flags[FL_N] = lane_n[0];
        nxt_flags[FL_Z] = flags_i[FL_Z] && sel_z;
        nxt_flags[FL_V] = lane_v[0];
        nxt_flags[FL_C] = lane_c[0];
      end
      OP_INC, OP_DEC: begin
        nxt_flags[FL_N] = lane_n[lane_sel];
        nxt_flags[FL_Z] = sel_z;
        nxt_flags[FL_V] = lane_v[lane_sel];
      end
      OP_DECADD, OP_DECSUB: begin
        nxt_res         = {dst_i[DW-1:8], da_res};
        nxt_flags[FL_N] = da_res[7];
        nxt_flags[FL_Z] = (da_res == 8'h00);
        nxt_flags[FL_C] = da_c;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        result_q <= illegal ? dst_i : nxt_res;
        flags_q  <= illegal ? flags_i : nxt_flags;
        err_q    <= illegal;
      end
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;
  assign err_o    = err_q;
  assign done_o   = done_q;
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk
  import arith_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [1:0]    size_i,
  input logic          imm_sel_i,
  input logic [DW-1:0] dst_i,
  input logic [DW-1:0] src_i,
  input logic [2:0]    step_i,
  input logic [FW-1:0] flags_i,
  input logic [DW-1:0] result_o,
  input logic [FW-1:0] flags_o,
  input logic          err_o,
  input logic          done_o
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && $stable(result_o) && $stable(flags_o) && $stable(err_o)));
  assert_bad_size_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'd3) |=> err_o);
  assert_addr_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && (op_i == OP_ADRADD || op_i == OP_ADRSUB)) |=> (flags_o == $past(flags_i)));
  assert_byte_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == SZ_BYTE) |=> (result_o[DW-1:8] == $past(dst_i[DW-1:8])));
  assert_word_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == SZ_WORD && op_i != OP_ADRADD && op_i != OP_ADRSUB)
      |=> (result_o[DW-1:16] == $past(dst_i[DW-1:16])));
  assert_err_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (result_o == $past(dst_i) && flags_o == $past(flags_i)));
endmodule

bind arith_unit arith_unit_chk u_chk (.*);

// File: tb/tb_arith_unit.sv
module tb_arith_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [1:0]  size_i;
  logic        imm_sel_i;
  logic [31:0] dst_i;
  logic [31:0] src_i;
  logic [2:0]  step_i;
  logic [4:0]  flags_i;
  logic [31:0] result_o;
  logic [4:0]  flags_o;
  logic        err_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  arith_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] r, input logic [4:0] f, input logic e);
    n_chk++;
    if (result_o !== r || flags_o !== f || err_o !== e || done_o !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: result=%h flags=%b err=%b done=%b expected result=%h flags=%b err=%b done=1",
               req, result_o, flags_o, err_o, done_o, r, f, e);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [1:0] sz, input logic imm,
                       input logic [31:0] d, input logic [31:0] s, input logic [2:0] st,
                       input logic [4:0] fl);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; size_i = sz; imm_sel_i = imm;
    dst_i = d; src_i = s; step_i = st; flags_i = fl;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    n_chk++;
    if (result_o !== 32'h0 || flags_o !== 5'h0 || err_o !== 1'b0 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: result=%h flags=%b err=%b done=%b expected all zero",
               result_o, flags_o, err_o, done_o);
    end
  endtask

  task automatic t_addsub;
    apply(4'd0, 2'd0, 1'b0, 32'hAABBCC7F, 32'h01, 3'd0, 5'b00000);
    chk("R3 byte add overflow", 32'hAABBCC80, 5'b11010, 1'b0);
    apply(4'd0, 2'd2, 1'b1, 32'hFFFFFFFF, 32'h1, 3'd0, 5'b00000);
    chk("R3 long add wrap", 32'h0, 5'b10101, 1'b0);
    apply(4'd1, 2'd1, 1'b0, 32'h12340000, 32'h1, 3'd0, 5'b00000);
    chk("R3 R10 word sub borrow", 32'h1234FFFF, 5'b11001, 1'b0);
  endtask

  task automatic t_bad_imm_sub;
    apply(4'd1, 2'd0, 1'b1, 32'h00000055, 32'h1, 3'd0, 5'b00100);
    chk("R4 R11 byte sub immediate", 32'h00000055, 5'b00100, 1'b1);
  endtask

  task automatic t_carry_chain;
    apply(4'd2, 2'd0, 1'b0, 32'h10, 32'h20, 3'd0, 5'b00101);
    chk("R5 addc nonzero clears Z", 32'h31, 5'b00000, 1'b0);
    apply(4'd2, 2'd0, 1'b0, 32'hFF, 32'h00, 3'd0, 5'b00001);
    chk("R5 addc zero keeps Z clear", 32'h0, 5'b10001, 1'b0);
    apply(4'd2, 2'd0, 1'b0, 32'hFF, 32'h00, 3'd0, 5'b00101);
    chk("R5 addc zero keeps Z set", 32'h0, 5'b10101, 1'b0);
    apply(4'd3, 2'd1, 1'b0, 32'h1234, 32'h1, 3'd0, 5'b00010);
    chk("R5 subc word illegal", 32'h1234, 5'b00010, 1'b1);
  endtask

  task automatic t_incdec;
    apply(4'd4, 2'd0, 1'b0, 32'h7, 32'h0, 3'd2, 5'b00000);
    chk("R6 byte inc by 2 illegal", 32'h7, 5'b00000, 1'b1);
    apply(4'd4, 2'd1, 1'b0, 32'h00007FFF, 32'h0, 3'd2, 5'b10001);
    chk("R6 word inc by 2", 32'h00008001, 5'b11011, 1'b0);
    apply(4'd5, 2'd2, 1'b0, 32'h1, 32'h0, 3'd1, 5'b00000);
    chk("R6 long dec to zero", 32'h0, 5'b00100, 1'b0);
  endtask

  task automatic t_addr;
    apply(4'd6, 2'd2, 1'b0, 32'hFFFFFFFE, 32'h0, 3'd4, 5'b01010);
    chk("R7 address add by 4", 32'h00000002, 5'b01010, 1'b0);
    apply(4'd7, 2'd2, 1'b0, 32'h100, 32'h0, 3'd3, 5'b00000);
    chk("R7 address step 3 illegal", 32'h100, 5'b00000, 1'b1);
    apply(4'd6, 2'd1, 1'b0, 32'h100, 32'h0, 3'd2, 5'b00000);
    chk("R7 address word illegal", 32'h100, 5'b00000, 1'b1);
  endtask

  task automatic t_decimal;
    apply(4'd8, 2'd0, 1'b0, 32'h1100009A, 32'h0, 3'd0, 5'b00000);
    chk("R8 adjust both digits", 32'h11000000, 5'b00101, 1'b0);
    apply(4'd8, 2'd0, 1'b0, 32'h15, 32'h0, 3'd0, 5'b10000);
    chk("R8 adjust on H", 32'h1B, 5'b10000, 1'b0);
    apply(4'd9, 2'd0, 1'b0, 32'hFA, 32'h0, 3'd0, 5'b10001);
    chk("R9 subtract adjust", 32'h94, 5'b11001, 1'b0);
    apply(4'd9, 2'd1, 1'b0, 32'hFA, 32'h0, 3'd0, 5'b00000);
    chk("R9 word adjust illegal", 32'hFA, 5'b00000, 1'b1);
  endtask

  task automatic t_illegal_codes;
    apply(4'd12, 2'd0, 1'b0, 32'hCAFE, 32'h1, 3'd1, 5'b00011);
    chk("R2 R11 opcode 12", 32'hCAFE, 5'b00011, 1'b1);
    apply(4'd0, 2'd3, 1'b0, 32'hBEEF, 32'h1, 3'd1, 5'b00000);
    chk("R2 size 3", 32'hBEEF, 5'b00000, 1'b1);
    apply(4'd0, 2'd0, 1'b0, 32'h0, 32'h0, 3'd0, 5'b00000);
    chk("R11 legal clears err", 32'h0, 5'b00100, 1'b0);
  endtask

  task automatic t_idle_hold;
    apply(4'd0, 2'd1, 1'b0, 32'h00000100, 32'h0001, 3'd0, 5'b00000);
    chk("R3 word add", 32'h00000101, 5'b00000, 1'b0);
    dst_i = 32'hFFFF; src_i = 32'hFFFF;
    repeat (3) @(negedge clk);
    n_chk++;
    if (result_o !== 32'h101 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle hold: result=%h done=%b expected result=00000101 done=0",
               result_o, done_o);
    end
  endtask

  initial begin
    rst = 1'b1; valid_i = 1'b0; op_i = '0; size_i = '0; imm_sel_i = 1'b0;
    dst_i = '0; src_i = '0; step_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_addsub();
    t_bad_imm_sub();
    t_carry_chain();
    t_incdec();
    t_addr();
    t_decimal();
    t_illegal_codes();
    t_idle_hold();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule